// File: doc/BRIEF.md
# AES Round Key Expander

This block turns an AES cipher key of 128, 192 or 256 bits into the full list of 32-bit round-key words (44, 52 or 60 of them, for 10, 12 or 14 rounds). The key, a size code and a mode are captured on a one-cycle `start` pulse. In on-demand mode an encryption engine pulls one word per `word_req` while it runs, so expansion keeps pace with consumption. In free-run mode the block expands one word every clock without being asked. Every word is written into an internal key store as it is made.

Decryption needs the words from the last round to the first, so the whole schedule must sit in the store before it is read. Once `ready` is high, each `rd_req` returns the next word in reverse round order: round Nr first and round 0 last, with the four words of a round kept in ascending order. A preload mode skips expansion entirely: pre-expanded words arrive on `load_valid`/`load_word` in ascending index order and fill the store directly.

The controller has four states. IDLE (after reset) waits for `start`. A `start` in any state moves to EXPAND (mode 0 or 1) or LOAD (mode 2) and resets the word index and reverse pointer. EXPAND moves to READY when the last word is produced. LOAD moves to READY when the last word is loaded. READY stays until the next `start`.

Top module: `aes_key_expander`

## Requirements
- R1: While reset is asserted and after its release, `ready`, `word_valid` and `rd_valid` are 0 until a `start` is accepted.
- R2: In on-demand mode (`mode`=0, and the reserved code 3), a `word_req` in EXPAND gives `word_valid`=1 with the next word on `word_out` one cycle later; words 0..Nk-1 equal the key words, key word j being `key_in[255-32j -: 32]`. Without a request `word_valid` is 0.
- R3: Word i (i >= Nk) equals word i-Nk XOR t; t is SubWord(RotWord(word i-1)) XOR {rcon,24'h0} when i mod Nk is 0, SubWord(word i-1) when Nk is 8 and i mod 8 is 4, else word i-1; rcon starts at 0x01 and is multiplied by x modulo 0x11B after each use.
- R4: `key_size` 0, 1, 2 selects Nk = 4, 6, 8 and a schedule of exactly 44, 52, 60 words.
- R5: `ready` rises in the cycle the last word appears and not earlier; a `word_req` outside EXPAND has no effect (`word_valid` stays 0).
- R6: In free-run mode (`mode`=1) one word is expanded per clock with no requests and no `word_valid`; `ready` is 1 exactly 44/52/60 cycles after the `start` edge.
- R7: In READY, each `rd_req` gives `rd_valid`=1 one cycle later with words in the order 4*Nr..4*Nr+3, 4*(Nr-1)..4*(Nr-1)+3, ..., 0..3, wrapping back to 4*Nr after word 3; `rd_req` outside READY has no effect.
- R8: In preload mode (`mode`=2), each `load_valid` stores `load_word` at the next ascending index; `ready` rises with the last word, and reverse reads return the loaded words.
- R9: A `start` in any state abandons the current schedule: `ready` falls the next cycle, the index restarts at word 0 and the reverse pointer restarts at round Nr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture key, size and mode; begin a new schedule |
| mode | input | 2 | 0 on-demand, 1 free-run, 2 preload, 3 as 0 |
| key_size | input | 2 | 0: 128-bit, 1: 192-bit, 2: 256-bit key (3 as 0) |
| key_in | input | 256 | Cipher key, word 0 in the top 32 bits |
| word_req | input | 1 | Request the next round-key word (on-demand) |
| word_valid | output | 1 | `word_out` carries the requested word |
| word_out | output | 32 | Expanded round-key word |
| load_valid | input | 1 | Preload strobe |
| load_word | input | 32 | Pre-expanded word to store |
| rd_req | input | 1 | Request next word in reverse round order |
| rd_valid | output | 1 | `rd_word` carries the reverse-order word |
| rd_word | output | 32 | Word read from the key store |
| ready | output | 1 | Full schedule is in the store |

## Verification
A corrupted sliding window or round constant shows at `word_out` at the first word whose recurrence uses it, at most Nk requests after the fault, and every later word carries the error, so comparing each word against an independent model locates the first bad index. A wrong index counter shows as `ready` rising one request early or late, visible in the very cycle of the last word. A wrong reverse pointer or store address shows on the first `rd_req` after `ready`, and a wrap fault on the word following round 0.

// File: rtl/aeskx_pkg.sv
package aeskx_pkg;

    typedef enum logic [1:0] {
        MODE_ON_DEMAND = 2'd0,
        MODE_FREE_RUN  = 2'd1,
        MODE_PRELOAD   = 2'd2
    } kx_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXPAND,
        ST_LOAD,
        ST_READY
    } kx_state_e;

    // multiply by x in GF(2^8), reduction 0x11B
    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int n = 0; n < 8; n++) begin
            if (b[n]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // a^254 is the multiplicative inverse (0 maps to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] pw;
        logic [7:0] res;
        pw  = a;
        res = 8'h01;
        for (int n = 1; n < 8; n++) begin
            pw  = gf_mul(pw, pw);
            res = gf_mul(res, pw);
        end
        return res;
    endfunction

    function automatic logic [7:0] sub_byte(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

endpackage

// File: rtl/aeskx_sbox.sv
module aeskx_sbox (
    input  logic [7:0] byte_in,
    output logic [7:0] byte_out
);
    import aeskx_pkg::*;

    always_comb byte_out = sub_byte(byte_in);

endmodule

// File: rtl/aeskx_subword.sv
module aeskx_subword #(
    parameter int WORD_W = 32,
    localparam int LANES = WORD_W / 8
) (
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_sub
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        aeskx_sbox u_sbox (
            .byte_in  (word_in[8*g +: 8]),
            .byte_out (word_sub[8*g +: 8])
        );
    end

endmodule

// File: rtl/aeskx_keystore.sv
module aeskx_keystore #(
    parameter int DEPTH  = 60,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
            assert_wr_addr_range_R4 : assert (int'(wr_addr) < DEPTH)
                else $error("key store write beyond depth");
        end
        if (rd_en) begin
            rd_data <= mem[rd_addr];
            assert_rd_addr_range_R7 : assert (int'(rd_addr) < DEPTH)
                else $error("key store read beyond depth");
        end
    end

endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander #(
    parameter int MAX_NK = 8,
    parameter int WORD_W = 32,
    localparam int KEY_W     = MAX_NK * WORD_W,
    localparam int MAX_WORDS = 4 * MAX_NK + 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [1:0]        key_size,
    input  logic [KEY_W-1:0]  key_in,
    input  logic              word_req,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_out,
    input  logic              load_valid,
    input  logic [WORD_W-1:0] load_word,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word,
    output logic              ready
);
    import aeskx_pkg::*;

    localparam int IDX_W = $clog2(MAX_WORDS + 1);
    localparam int SEL_W = $clog2(MAX_NK);
    localparam int AW    = $clog2(MAX_WORDS);

    kx_state_e         state_q, state_d;
    kx_mode_e          mode_q, mode_dec;
    logic [SEL_W-1:0]  nkm1_q, nkm1_d;
    logic [IDX_W-1:0]  total_q, total_d;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  rp_q;
    logic [SEL_W-1:0]  imod_q;
    logic [7:0]        rcon_q;
    logic [KEY_W-1:0]  key_q;
    logic [WORD_W-1:0] win_q [MAX_NK];
    logic [WORD_W-1:0] key_word [MAX_NK];

    logic              step, load_step, rd_step, last, in_key;
    logic [WORD_W-1:0] prev_w, back_w, rot_w, sub_in, sub_out, temp_w, new_w;
    logic [IDX_W-1:0]  rev_addr;

    // ---------------- capture decode ----------------
    always_comb begin
        unique case (mode)
            2'd1:    mode_dec = MODE_FREE_RUN;
            2'd2:    mode_dec = MODE_PRELOAD;
            default: mode_dec = MODE_ON_DEMAND;
        endcase
        unique case (key_size)
            2'd1:    begin nkm1_d = SEL_W'(5); total_d = IDX_W'(52); end
            2'd2:    begin nkm1_d = SEL_W'(7); total_d = IDX_W'(60); end
            default: begin nkm1_d = SEL_W'(3); total_d = IDX_W'(44); end
        endcase
    end

    // ---------------- strobes ----------------
    assign step      = !start && state_q == ST_EXPAND
                       && (mode_q == MODE_FREE_RUN || word_req);
    assign load_step = !start && state_q == ST_LOAD && load_valid;
    assign rd_step   = !start && state_q == ST_READY && rd_req;
    assign last      = idx_q == total_q - IDX_W'(1);
    assign in_key    = idx_q <= IDX_W'(nkm1_q);

    // ---------------- recurrence ----------------
    always_comb begin
        for (int j = 0; j < MAX_NK; j++)
            key_word[j] = key_q[KEY_W-1-j*WORD_W -: WORD_W];
    end

    assign prev_w = win_q[0];
    assign back_w = win_q[nkm1_q];
    assign rot_w  = {prev_w[WORD_W-9:0], prev_w[WORD_W-1 -: 8]};
    assign sub_in = (imod_q == '0) ? rot_w : prev_w;

    aeskx_subword #(.WORD_W(WORD_W)) u_subword (
        .word_in  (sub_in),
        .word_sub (sub_out)
    );

    always_comb begin
        if (imod_q == '0)
            temp_w = sub_out ^ {rcon_q, {(WORD_W-8){1'b0}}};
        else if (nkm1_q == SEL_W'(7) && imod_q == SEL_W'(4))
            temp_w = sub_out;
        else
            temp_w = prev_w;
        new_w = in_key ? key_word[idx_q[SEL_W-1:0]] : (back_w ^ temp_w);
    end

    // reverse order: round Nr first, words ascending inside a round
    assign rev_addr = total_q - IDX_W'(4) - {rp_q[IDX_W-1:2], 2'b00}
                      + IDX_W'(rp_q[1:0]);

    aeskx_keystore #(.DEPTH(MAX_WORDS), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .wr_en   (step || load_step),
        .wr_addr (idx_q[AW-1:0]),
        .wr_data (load_step ? load_word : new_w),
        .rd_en   (rd_step),
        .rd_addr (rev_addr[AW-1:0]),
        .rd_data (rd_word)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = (mode_dec == MODE_PRELOAD) ? ST_LOAD : ST_EXPAND;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_EXPAND: if (step && last)      state_d = ST_READY;
                ST_LOAD:   if (load_step && last) state_d = ST_READY;
                ST_READY:  state_d = ST_READY;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    assign ready = state_q == ST_READY;

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_ON_DEMAND;
            nkm1_q     <= SEL_W'(3);
            total_q    <= IDX_W'(44);
            key_q      <= '0;
            idx_q      <= '0;
            imod_q     <= '0;
            rcon_q     <= 8'h01;
            rp_q       <= '0;
            word_valid <= 1'b0;
            word_out   <= '0;
            rd_valid   <= 1'b0;
            for (int j = 0; j < MAX_NK; j++) win_q[j] <= '0;
        end else begin
            word_valid <= 1'b0;
            rd_valid   <= 1'b0;
            if (start) begin
                mode_q  <= mode_dec;
                nkm1_q  <= nkm1_d;
                total_q <= total_d;
                key_q   <= key_in;
                idx_q   <= '0;
                imod_q  <= '0;
                rcon_q  <= 8'h01;
                rp_q    <= '0;
            end else begin
                if (step) begin
                    idx_q  <= idx_q + IDX_W'(1);
                    imod_q <= (imod_q == nkm1_q) ? '0 : imod_q + SEL_W'(1);
                    if (!in_key && imod_q == '0) rcon_q <= gf_xtime(rcon_q);
                    win_q[0] <= new_w;
                    for (int j = 1; j < MAX_NK; j++) win_q[j] <= win_q[j-1];
                    if (mode_q != MODE_FREE_RUN) begin
                        word_valid <= 1'b1;
                        word_out   <= new_w;
                    end
                end
                if (load_step) idx_q <= idx_q + IDX_W'(1);
                if (rd_step) begin
                    rp_q     <= (rp_q == total_q - IDX_W'(1)) ? '0 : rp_q + IDX_W'(1);
                    rd_valid <= 1'b1;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    assert_valid_after_req_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(word_req) && $past(state_q) == ST_EXPAND);

    assert_rcon_advances_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (step && !in_key && imod_q == '0) |=> rcon_q != $past(rcon_q));

    assert_index_bound_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= total_q);

    assert_ready_full_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_READY) |-> idx_q == total_q);

    assert_free_run_step_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPAND && mode_q == MODE_FREE_RUN && !start)
        |=> idx_q == $past(idx_q) + IDX_W'(1));

    assert_rd_in_ready_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req) && $past(state_q) == ST_READY);

    assert_restart_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        start |=> idx_q == '0 && rp_q == '0 && !ready);

endmodule

// File: tb/aes_key_expander_bench.sv
`timescale 1ns/1ps
module aes_key_expander_bench;

    logic         clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n = 1'b0, start = 1'b0, word_req = 1'b0;
    logic         load_valid = 1'b0, rd_req = 1'b0;
    logic [1:0]   mode = 2'd0, key_size = 2'd0;
    logic [255:0] key_in = '0;
    logic [31:0]  load_word = '0;
    logic         word_valid, rd_valid, ready;
    logic [31:0]  word_out, rd_word;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0]  sb [256];
    logic [31:0] ref_w [60];
    int          ref_nk, ref_total;

    localparam logic [255:0] KEY128 =
        {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
    localparam logic [255:0] KEY192 =
        {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0};
    localparam logic [255:0] KEY256 =
        256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;

    aes_key_expander u_aes_key_expander (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .key_size(key_size), .key_in(key_in), .word_req(word_req),
        .word_valid(word_valid), .word_out(word_out),
        .load_valid(load_valid), .load_word(load_word),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_word(rd_word),
        .ready(ready)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
        end
    endtask

    // S-box from the generator-walk method, independent of the RTL
    task automatic build_sbox();
        logic [7:0] p = 8'h01, q = 8'h01, x;
        do begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b00};
            q = q ^ {q[3:0], 4'h0};
            if (q[7]) q = q ^ 8'h09;
            x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
            sb[p] = x ^ 8'h63;
        end while (p != 8'h01);
        sb[0] = 8'h63;
    endtask

    function automatic logic [31:0] subw(input logic [31:0] t);
        return {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
    endfunction

    task automatic ref_expand(input int ks, input logic [255:0] key);
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        ref_nk    = (ks == 1) ? 6 : (ks == 2) ? 8 : 4;
        ref_total = 4 * ref_nk + 28;
        for (int i = 0; i < ref_total; i++) begin
            if (i < ref_nk) begin
                ref_w[i] = key[255-32*i -: 32];
            end else begin
                t = ref_w[i-1];
                if (i % ref_nk == 0) begin
                    t  = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                    rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1B : 8'h00);
                end else if (ref_nk == 8 && i % 8 == 4) begin
                    t = subw(t);
                end
                ref_w[i] = ref_w[i-ref_nk] ^ t;
            end
        end
    endtask

    function automatic int rev_idx(input int k);
        int kk;
        kk = k % ref_total;
        return 4 * (ref_nk + 6 - kk / 4) + kk % 4;
    endfunction

    task automatic do_start(input logic [1:0] m, input logic [1:0] ks,
                            input logic [255:0] key);
        start = 1'b1; mode = m; key_size = ks; key_in = key;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_on_demand(input int count);
        for (int i = 0; i < count; i++) begin
            word_req = 1'b1;
            @(negedge clk);
            word_req = 1'b0;
            if (i < ref_nk)
                chk(word_valid === 1'b1 && word_out === ref_w[i], "R2 key word", word_out, ref_w[i]);
            else
                chk(word_valid === 1'b1 && word_out === ref_w[i], "R3 expanded word", word_out, ref_w[i]);
            chk(ready === (i == ref_total - 1), "R4 R5 ready timing", 32'(ready), 32'(i == ref_total - 1));
            if (i % 5 == 2) begin
                @(negedge clk);
                chk(word_valid === 1'b0, "R2 no request no word", 32'(word_valid), 32'h0);
            end
        end
    endtask

    task automatic run_reverse(input string tag);
        for (int k = 0; k <= ref_total; k++) begin
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
            chk(rd_valid === 1'b1 && rd_word === ref_w[rev_idx(k)], tag, rd_word, ref_w[rev_idx(k)]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        build_sbox();

        // model against the published schedule ends
        ref_expand(0, KEY128);
        chk(ref_w[4] === 32'ha0fafe17 && ref_w[43] === 32'hb6630ca6, "R3 model 128", ref_w[43], 32'hb6630ca6);
        ref_expand(1, KEY192);
        chk(ref_w[6] === 32'hfe0c91f7 && ref_w[51] === 32'h01002202, "R3 model 192", ref_w[51], 32'h01002202);
        ref_expand(2, KEY256);
        chk(ref_w[8] === 32'h9ba35411 && ref_w[59] === 32'h706c631e, "R3 model 256", ref_w[59], 32'h706c631e);

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!ready && !word_valid && !rd_valid, "R1 in reset", {29'h0, ready, word_valid, rd_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ready && !word_valid && !rd_valid, "R1 after reset", {29'h0, ready, word_valid, rd_valid}, 32'h0);

        // requests while idle are ignored
        word_req = 1'b1; rd_req = 1'b1;
        @(negedge clk);
        word_req = 1'b0; rd_req = 1'b0;
        chk(word_valid === 1'b0, "R5 req in IDLE", 32'(word_valid), 32'h0);
        chk(rd_valid === 1'b0, "R7 rd in IDLE", 32'(rd_valid), 32'h0);

        // on-demand, all three sizes
        for (int ks = 0; ks < 3; ks++) begin
            ref_expand(ks, (ks == 0) ? KEY128 : (ks == 1) ? KEY192 : KEY256);
            do_start(2'd0, 2'(ks), (ks == 0) ? KEY128 : (ks == 1) ? KEY192 : KEY256);
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
            chk(rd_valid === 1'b0 && word_valid === 1'b0, "R7 rd during expansion", {30'h0, rd_valid, word_valid}, 32'h0);
            run_on_demand(ref_total);
            word_req = 1'b1;
            @(negedge clk);
            word_req = 1'b0;
            chk(word_valid === 1'b0, "R5 req after ready", 32'(word_valid), 32'h0);
            run_reverse("R7 reverse order");
        end

        // free-run, 256-bit key
        ref_expand(2, KEY256);
        do_start(2'd1, 2'd2, KEY256);
        for (int c = 1; c < ref_total; c++) begin
            @(negedge clk);
            chk(word_valid === 1'b0 && ready === 1'b0, "R6 free-run busy", {30'h0, word_valid, ready}, 32'h0);
        end
        @(negedge clk);
        chk(ready === 1'b1, "R6 free-run ready time", 32'(ready), 32'h1);
        run_reverse("R6 free-run store");

        // free-run, 128-bit key with reverse wrap
        ref_expand(0, KEY128);
        do_start(2'd1, 2'd0, KEY128);
        repeat (ref_total) @(negedge clk);
        chk(ready === 1'b1, "R6 free-run 128 ready", 32'(ready), 32'h1);
        run_reverse("R7 wrap 128");

        // preload, 192-bit size
        ref_nk = 6; ref_total = 52;
        for (int i = 0; i < 52; i++) ref_w[i] = 32'h9E3779B9 * (i + 1) ^ 32'hA5000000;
        do_start(2'd2, 2'd1, '0);
        for (int i = 0; i < ref_total; i++) begin
            load_valid = 1'b1; load_word = ref_w[i];
            @(negedge clk);
            load_valid = 1'b0;
            chk(ready === (i == ref_total - 1) && word_valid === 1'b0, "R8 preload progress",
                {30'h0, ready, word_valid}, {31'h0, 1'(i == ref_total - 1)} << 1);
        end
        run_reverse("R8 preload reverse");

        // restart mid-expansion and from READY
        ref_expand(1, KEY192);
        do_start(2'd0, 2'd1, KEY192);
        run_on_demand(5);
        ref_expand(0, KEY128);
        do_start(2'd0, 2'd0, KEY128);
        chk(ready === 1'b0, "R9 restart mid-run", 32'(ready), 32'h0);
        run_on_demand(ref_total);
        ref_expand(2, KEY256);
        do_start(2'd1, 2'd2, KEY256);
        chk(ready === 1'b0, "R9 restart from READY", 32'(ready), 32'h0);
        repeat (ref_total) @(negedge clk);
        run_reverse("R9 reverse after restart");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule